// File: doc/BRIEF.md
# Indirect Command Bridge

This block sits behind a 64-bit register port and turns software commands into single transfers on an internal peripheral bus with 32-bit addresses. Software first loads a data word and then writes one control word. That control word holds the direction, the byte count and the bus address. The bridge runs the transfer and posts the outcome in a status word. The status word clears itself when software reads it.

Write data leaves the bridge in big-endian byte order: byte 0 is the most significant byte of the stored data word. Read data comes back the same way. While a transfer is outstanding the bridge drops its ready line, so every register access, including the next command, waits until the current transfer completes.

Top module: `cmd_bridge`

## Requirements
- R1: The register is chosen by byte address bits [4:3]: 0 is control, 1 is reset, 2 is status and 3 is data. All other address bits are ignored. Reads of control or reset return zero. An access whose size is not 8 bytes is accepted but changes no register, and if it is a read it returns zero.
- R2: A data-register write stores bits [63:32] of the written word. A data-register read returns the stored word in bits [63:32], with bits [31:0] zero.
- R3: A control write starts one bus transfer. The transfer is started when the size field, bits [59:56], is 8 or less. Bit 48 set means a read and clear means a write. Bits [31:0] give the address. From the cycle after acceptance, the bus outputs carry that direction, size and address.
- R4: A control write with a size field above 8 starts no transfer and leaves status unchanged. A size of exactly 8 is accepted.
- R5: When a read completes without error, status becomes bit 11 (done) set, plus the returned 32-bit word in bits [57:26].
- R6: When a read completes with an error, status becomes bit 11 set with bits [57:26] all ones.
- R7: A bus write drives the stored data word on bus_wdata_o, with byte 0 in bits [31:24]. On completion, status becomes exactly bit 11, whether or not an error was reported.
- R8: A status read returns the current status value, and the status is zero afterwards.
- R9: Writes to the reset register and to the status register change nothing.
- R10: From acceptance of a command until the bus handshake completes, busy_o is high, reg_rdy_o is low and bus_valid_o is held with stable command fields.
- R11: After reset, status and data are zero, busy_o and bus_valid_o are low, and reg_rdy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register access request |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | REG_AW | Byte address of the access |
| reg_size_i | input | 4 | Access size in bytes |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdy_o | output | 1 | Access accepted when high together with request |
| reg_rvalid_o | output | 1 | Read data valid, one cycle after acceptance |
| reg_rdata_o | output | 64 | Register read data |
| busy_o | output | 1 | Bus transfer outstanding |
| bus_valid_o | output | 1 | Bus command valid |
| bus_ready_i | input | 1 | Bus target completes the transfer |
| bus_write_o | output | 1 | 1 = bus write |
| bus_addr_o | output | 32 | Bus address |
| bus_size_o | output | 4 | Bus transfer byte count |
| bus_wdata_o | output | 32 | Bus write data, big-endian |
| bus_rdata_i | input | 32 | Bus read data, big-endian |
| bus_err_i | input | 1 | Error response, valid with ready |

## Verification
A stuck or wrongly cleared busy state appears at once: busy_o and reg_rdy_o are compared with a reference model on every clock, so it is caught in the first cycle that differs. A wrong command latch shows up on the bus fields in the cycle after acceptance. A wrong status update stays hidden until the next status read, which the bench issues straight after each transfer. A wrong clear-on-read is found by a second status read that must return zero.

// File: rtl/cmdbr_pkg.sv
package cmdbr_pkg;
  localparam int REG_DW      = 64;
  localparam int BUS_AW      = 32;
  localparam int BUS_DW      = 32;
  localparam int SIZE_W      = 4;
  localparam int MAX_BYTES   = 8;
  localparam int DONE_BIT    = 11;
  localparam int RDATA_LSB   = 26;
  localparam int RD_FLAG_BIT = 48;
  localparam int SIZE_LSB    = 56;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_RST  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_DATA = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic              rd;
    logic [SIZE_W-1:0] size;
    logic [BUS_AW-1:0] addr;
  } bus_cmd_t;

  function automatic logic [REG_DW-1:0] stat_word(logic rd, logic err,
                                                  logic [BUS_DW-1:0] d);
    logic [REG_DW-1:0] w;
    w = '0;
    w[DONE_BIT] = 1'b1;
    if (rd) w[RDATA_LSB +: BUS_DW] = err ? '1 : d;
    return w;
  endfunction
endpackage

// File: rtl/cmdbr_regs.sv
module cmdbr_regs
  import cmdbr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              we_i,
  input  reg_sel_e          sel_i,
  input  logic              ok_i,
  input  logic [REG_DW-1:0] wdata_i,
  input  logic              done_i,
  input  logic              done_rd_i,
  input  logic              done_err_i,
  input  logic [BUS_DW-1:0] done_rdata_i,
  output logic              launch_o,
  output bus_cmd_t          cmd_o,
  output logic [BUS_DW-1:0] data_o,
  output logic              rvalid_o,
  output logic [REG_DW-1:0] rdata_o
);
  logic              wr_ok, rd_acc, stat_rd;
  logic [SIZE_W-1:0] size_f;
  logic [BUS_DW-1:0] data_q;
  logic [REG_DW-1:0] stat_q;

  assign wr_ok   = acc_i & we_i & ok_i;
  assign rd_acc  = acc_i & ~we_i;
  assign stat_rd = rd_acc & ok_i & (sel_i == SEL_STAT);
  assign size_f  = wdata_i[SIZE_LSB +: SIZE_W];

  assign launch_o   = wr_ok && (sel_i == SEL_CTRL) && (size_f <= SIZE_W'(MAX_BYTES));
  assign cmd_o.rd   = wdata_i[RD_FLAG_BIT];
  assign cmd_o.size = size_f;
  assign cmd_o.addr = wdata_i[BUS_AW-1:0];
  assign data_o     = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
    end else if (wr_ok && sel_i == SEL_DATA) begin
      data_q <= wdata_i[REG_DW-1 -: BUS_DW];
    end
  end

  // completion and status read never coincide: accesses stall while busy
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
    end else if (done_i) begin
      stat_q <= stat_word(done_rd_i, done_err_i, done_rdata_i);
    end else if (stat_rd) begin
      stat_q <= '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd_acc;
      rdata_o  <= '0;
      if (rd_acc && ok_i) begin
        unique case (sel_i)
          SEL_STAT: rdata_o <= stat_q;
          SEL_DATA: rdata_o <= {data_q, {(REG_DW-BUS_DW){1'b0}}};
          default:  rdata_o <= '0;
        endcase
      end
    end
  end

  p_stat_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd && !done_i) |=> (stat_q == '0) && (rdata_o == $past(stat_q)));

  p_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> stat_q[DONE_BIT]);

  p_err_ones_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && done_rd_i && done_err_i) |=> (stat_q[RDATA_LSB +: BUS_DW] == '1));
endmodule

// File: rtl/cmdbr_master.sv
module cmdbr_master
  import cmdbr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  bus_cmd_t          cmd_i,
  input  logic [BUS_DW-1:0] data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              done_rd_o,
  output logic              done_err_o,
  output logic [BUS_DW-1:0] done_rdata_o,
  output logic              bus_valid_o,
  input  logic              bus_ready_i,
  output logic              bus_write_o,
  output logic [BUS_AW-1:0] bus_addr_o,
  output logic [SIZE_W-1:0] bus_size_o,
  output logic [BUS_DW-1:0] bus_wdata_o,
  input  logic [BUS_DW-1:0] bus_rdata_i,
  input  logic              bus_err_i
);
  logic              busy_q;
  bus_cmd_t          cmd_q;
  logic [BUS_DW-1:0] wd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cmd_q  <= '0;
      wd_q   <= '0;
    end else if (launch_i && !busy_q) begin
      busy_q <= 1'b1;
      cmd_q  <= cmd_i;
      wd_q   <= data_i;
    end else if (busy_q && bus_ready_i) begin
      busy_q <= 1'b0;
    end
  end

  assign busy_o       = busy_q;
  assign bus_valid_o  = busy_q;
  assign bus_write_o  = ~cmd_q.rd;
  assign bus_addr_o   = cmd_q.addr;
  assign bus_size_o   = cmd_q.size;
  assign bus_wdata_o  = wd_q;
  assign done_o       = busy_q & bus_ready_i;
  assign done_rd_o    = cmd_q.rd;
  assign done_err_o   = bus_err_i;
  assign done_rdata_o = bus_rdata_i;

  p_launch_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |-> !busy_q);

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && !bus_ready_i) |=>
      (bus_valid_o && $stable(bus_addr_o) && $stable(bus_write_o) && $stable(bus_size_o)));
endmodule

// File: rtl/cmd_bridge.sv
module cmd_bridge
  import cmdbr_pkg::*;
#(
  parameter int REG_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [3:0]        reg_size_i,
  input  logic [63:0]       reg_wdata_i,
  output logic              reg_rdy_o,
  output logic              reg_rvalid_o,
  output logic [63:0]       reg_rdata_o,
  output logic              busy_o,
  output logic              bus_valid_o,
  input  logic              bus_ready_i,
  output logic              bus_write_o,
  output logic [31:0]       bus_addr_o,
  output logic [3:0]        bus_size_o,
  output logic [31:0]       bus_wdata_o,
  input  logic [31:0]       bus_rdata_i,
  input  logic              bus_err_i
);
  localparam int SEL_LSB = 3;

  logic              acc, ok, launch, done, done_rd, done_err;
  reg_sel_e          sel;
  bus_cmd_t          cmd;
  logic [BUS_DW-1:0] data, done_rdata;
  logic              unused_addr;

  assign reg_rdy_o   = ~busy_o;
  assign acc         = reg_req_i & reg_rdy_o;
  assign ok          = (reg_size_i == 4'(REG_DW / 8));
  assign sel         = reg_sel_e'(reg_addr_i[SEL_LSB +: 2]);
  assign unused_addr = ^{reg_addr_i[REG_AW-1:SEL_LSB+2], reg_addr_i[SEL_LSB-1:0]};

  cmdbr_regs i_regs (
    .clk_i, .rst_ni,
    .acc_i(acc), .we_i(reg_we_i), .sel_i(sel), .ok_i(ok), .wdata_i(reg_wdata_i),
    .done_i(done), .done_rd_i(done_rd), .done_err_i(done_err), .done_rdata_i(done_rdata),
    .launch_o(launch), .cmd_o(cmd), .data_o(data),
    .rvalid_o(reg_rvalid_o), .rdata_o(reg_rdata_o)
  );

  cmdbr_master i_master (
    .clk_i, .rst_ni,
    .launch_i(launch), .cmd_i(cmd), .data_i(data),
    .busy_o, .done_o(done), .done_rd_o(done_rd), .done_err_o(done_err),
    .done_rdata_o(done_rdata),
    .bus_valid_o, .bus_ready_i, .bus_write_o, .bus_addr_o, .bus_size_o,
    .bus_wdata_o, .bus_rdata_i, .bus_err_i
  );

  p_oversize_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && reg_we_i && ok && sel == SEL_CTRL && reg_wdata_i[SIZE_LSB +: SIZE_W] > 4'd8)
      |=> !busy_o);

  p_rdy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !reg_rdy_o && bus_valid_o);
endmodule

// File: tb/test_cmd_bridge.sv
module test_cmd_bridge;
  localparam int CLK_P = 10;
  localparam logic [63:0] DONE = 64'h800;

  logic clk = 0, rst_ni = 0;
  logic reg_req = 0, reg_we = 0;
  logic [7:0] reg_addr = 0;
  logic [3:0] reg_size = 8;
  logic [63:0] reg_wdata = 0;
  logic reg_rdy_o, reg_rvalid_o, busy_o, bus_valid_o, bus_write_o;
  logic [63:0] reg_rdata_o;
  logic [31:0] bus_addr_o, bus_wdata_o;
  logic [3:0] bus_size_o;
  logic bus_ready = 0, bus_err = 0;
  logic [31:0] bus_rdata = 0;

  int total = 0, bad = 0, lat = 0, lat_cnt = 0;
  bit fin = 0;
  logic [31:0] mem [16];

  // reference model state
  logic m_busy = 0, m_rd = 0, m_rvalid = 0;
  logic [63:0] m_stat = 0, m_rdata = 0;
  logic [31:0] m_data = 0, m_addr = 0, m_wd = 0;
  logic [3:0] m_size = 0;

  always #(CLK_P/2) clk = ~clk;

  cmd_bridge i_cmd_bridge (
    .clk_i(clk), .rst_ni, .reg_req_i(reg_req), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_size_i(reg_size), .reg_wdata_i(reg_wdata), .reg_rdy_o, .reg_rvalid_o,
    .reg_rdata_o, .busy_o, .bus_valid_o, .bus_ready_i(bus_ready), .bus_write_o,
    .bus_addr_o, .bus_size_o, .bus_wdata_o, .bus_rdata_i(bus_rdata), .bus_err_i(bus_err)
  );

  task automatic chk(bit c, string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!c) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] ctrl(bit rd, int sz, logic [31:0] a);
    return (64'(rd) << 48) | (64'(sz) << 56) | 64'(a);
  endfunction

  function automatic bit is_err(logic [31:0] a);
    return a[31:28] == 4'hF;
  endfunction

  // one clock: responder, model update, compare at next negedge
  task automatic step();
    logic n_busy, n_rvalid;
    logic [63:0] n_stat, n_rdata;
    logic [31:0] n_data;
    logic [1:0] sel;
    bus_ready = 0; bus_err = 0; bus_rdata = 32'h0;
    if (bus_valid_o) begin
      if (lat_cnt >= lat) begin
        bus_ready = 1; lat_cnt = 0;
        bus_err = is_err(bus_addr_o);
        bus_rdata = bus_err ? 32'h5A5A_0F0F : mem[bus_addr_o[5:2]];
      end else lat_cnt++;
    end else lat_cnt = 0;
    n_busy = m_busy; n_stat = m_stat; n_data = m_data; n_rvalid = 0; n_rdata = 0;
    if (m_busy && bus_ready) begin
      n_busy = 0;
      if (m_rd) n_stat = DONE | (64'(is_err(m_addr) ? 32'hFFFF_FFFF : mem[m_addr[5:2]]) << 26);
      else begin
        n_stat = DONE;
        if (!is_err(m_addr)) mem[m_addr[5:2]] = m_wd;
      end
    end
    if (reg_req && !m_busy) begin
      sel = reg_addr[4:3];
      if (!reg_we) n_rvalid = 1;
      if (reg_size == 8) begin
        if (reg_we) begin
          if (sel == 0 && reg_wdata[59:56] <= 8) begin
            n_busy = 1; m_rd = reg_wdata[48]; m_size = reg_wdata[59:56];
            m_addr = reg_wdata[31:0]; m_wd = m_data;
          end
          if (sel == 3) n_data = reg_wdata[63:32];
        end else begin
          if (sel == 2) begin n_rdata = m_stat; n_stat = 0; end
          if (sel == 3) n_rdata = {m_data, 32'h0};
        end
      end
    end
    @(negedge clk);
    m_busy = n_busy; m_stat = n_stat; m_data = n_data; m_rvalid = n_rvalid; m_rdata = n_rdata;
    chk(busy_o == m_busy, "R10 busy", 64'(busy_o), 64'(m_busy));
    chk(reg_rdy_o == !m_busy, "R10 rdy", 64'(reg_rdy_o), 64'(!m_busy));
    chk(bus_valid_o == m_busy, "R3 valid", 64'(bus_valid_o), 64'(m_busy));
    if (m_busy) begin
      chk(bus_addr_o == m_addr, "R3 addr", 64'(bus_addr_o), 64'(m_addr));
      chk(bus_write_o == !m_rd, "R3 dir", 64'(bus_write_o), 64'(!m_rd));
      chk(bus_size_o == m_size, "R3 size", 64'(bus_size_o), 64'(m_size));
      if (!m_rd) chk(bus_wdata_o == m_wd, "R7 wdata", 64'(bus_wdata_o), 64'(m_wd));
    end
    chk(reg_rvalid_o == m_rvalid, "R1 rvalid", 64'(reg_rvalid_o), 64'(m_rvalid));
    if (m_rvalid) chk(reg_rdata_o == m_rdata, "R8 rdata", reg_rdata_o, m_rdata);
  endtask

  task automatic access(bit we, logic [7:0] a, logic [63:0] d, logic [3:0] sz);
    bit acc;
    reg_req = 1; reg_we = we; reg_addr = a; reg_wdata = d; reg_size = sz;
    do begin acc = !m_busy; step(); end while (!acc);
    reg_req = 0;
  endtask

  task automatic wr(int sel, logic [63:0] d);
    access(1, 8'(sel << 3), d, 8);
  endtask

  task automatic rd(logic [7:0] a, logic [63:0] exp, string tag, logic [3:0] sz = 8);
    access(0, a, 0, sz);
    chk(reg_rvalid_o && reg_rdata_o == exp, tag, reg_rdata_o, exp);
  endtask

  task automatic idle();
    while (m_busy) step();
    step();
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'h0;
    #(CLK_P * 150000);
    bad++; total++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    if (!fin) begin
      fin = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    chk(!busy_o && !bus_valid_o && reg_rdy_o, "R11 idle", 64'(busy_o), 0);
    rd(8'h10, 0, "R11 status");
    rd(8'h18, 0, "R11 data");
    // R2
    wr(3, 64'hA1B2_C3D4_5566_7788);
    rd(8'h18, 64'hA1B2_C3D4_0000_0000, "R2 data");
    // R7 bus write, R8 clear-on-read
    wr(0, ctrl(0, 4, 32'h100)); idle();
    rd(8'h10, DONE, "R7 status");
    rd(8'h10, 0, "R8 cleared");
    // R5 read back
    lat = 2;
    wr(0, ctrl(1, 4, 32'h100)); idle();
    rd(8'h10, DONE | (64'hA1B2_C3D4 << 26), "R5 status");
    // R6 failed read
    wr(0, ctrl(1, 4, 32'hF000_0000)); idle();
    rd(8'h10, DONE | (64'hFFFF_FFFF << 26), "R6 status");
    // R7 failed write still only done
    wr(0, ctrl(0, 2, 32'hF000_0010)); idle();
    rd(8'h10, DONE, "R7 err status");
    // R4 oversize leaves status
    wr(0, ctrl(1, 4, 32'h100)); idle();
    wr(0, ctrl(1, 9, 32'h100)); step();
    chk(!busy_o, "R4 no launch", 64'(busy_o), 0);
    rd(8'h10, DONE | (64'hA1B2_C3D4 << 26), "R4 status kept");
    // R4 size 8 boundary accepted
    wr(3, 64'h0BAD_F00D_0000_0000);
    wr(0, ctrl(0, 8, 32'h104));
    chk(busy_o, "R4 size8 launch", 64'(busy_o), 1);
    idle();
    wr(0, ctrl(1, 8, 32'h104)); idle();
    rd(8'h10, DONE | (64'h0BAD_F00D << 26), "R4 size8 data");
    // R9 writes to reset/status ignored
    wr(0, ctrl(1, 4, 32'h100)); idle();
    wr(2, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(1, 64'hFFFF_FFFF_FFFF_FFFF);
    chk(!busy_o, "R9 no launch", 64'(busy_o), 0);
    rd(8'h10, DONE | (64'hA1B2_C3D4 << 26), "R9 status kept");
    rd(8'h18, 64'h0BAD_F00D_0000_0000, "R9 data kept");
    // R1 control/reset reads zero, select from bits [4:3]
    rd(8'h00, 0, "R1 ctrl zero");
    rd(8'h08, 0, "R1 reset zero");
    rd(8'hFD, 64'h0BAD_F00D_0000_0000, "R1 sel bits");
    // R1 wrong size ignored
    access(1, 8'h18, 64'h1111_2222_0000_0000, 4);
    rd(8'h18, 0, "R1 size4 read", 4);
    rd(8'h18, 64'h0BAD_F00D_0000_0000, "R1 size4 write ignored");
    // R10 stall behind a slow transfer
    lat = 5;
    wr(0, ctrl(1, 4, 32'h104));
    chk(!reg_rdy_o, "R10 stalled", 64'(reg_rdy_o), 0);
    wr(3, 64'h7777_8888_0000_0000);
    chk(!busy_o, "R10 after", 64'(busy_o), 0);
    rd(8'h18, 64'h7777_8888_0000_0000, "R10 data");
    rd(8'h10, DONE | (64'h0BAD_F00D << 26), "R10 status");
    idle();
    if (!fin) begin
      fin = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule